// File: doc/BRIEF.md
# Trigger Command Source Selector and Mapper

This block decides where trigger commands come from and sends the chosen stream to a set of front-end control rings and to a backplane output that feeds the off-detector readout cards. There are two sources. The remote source is a timing receiver that supplies broadcast command bytes and a level-1 accept strobe. The local source is an on-board command generator that supplies ring commands directly, plus its own level-1 accept strobe.

The block picks the source on its own from the receiver's ready flag. Software can override that choice and force the local source. Subsystems assign ring trigger codes differently, so remote broadcast bytes go through a writable 64-entry table that turns each byte into a 3-bit ring command. A small register port loads the table, sets the force bit and reports which source is actually in effect. A source change waits for an edge where nothing is being sent, so a command is never split across two sources. A level-1 accept that coincides with a broadcast command goes out first, and the broadcast command follows one cycle later.

Top module: `trig_cmd_router`

## Requirements
- R1: In local mode, the outputs carry only the local inputs (loc_l1a, and loc_cmd when loc_cmd_valid is set), and remote inputs have no effect. In remote mode, the outputs carry only rx_l1a and the mapped rx_bcast_code, and local inputs have no effect.
- R2: With the force bit clear, the requested mode is remote while rx_ready is 1 and local while rx_ready is 0.
- R3: The force bit is bit 0 of the control register at address 0x40, and it is readable there. While it is 1, the requested mode is local whatever rx_ready is.
- R4: A valid broadcast byte in remote mode is mapped through table entry rx_bcast_code[7:2]. Entry n sits at address n (0..63), holds cfg_wdata[2:0] and reads back on cfg_rdata[2:0]. An entry value of 3'b000 means no command, and no output is produced for it.
- R5: The command register drives every ring slot ring_cmd[3*i+2:3*i] and bp_cmd with the same 3-bit code. A command presented before a clock edge appears on these outputs after that edge, and 3'b000 means idle.
- R6: A level-1 accept from the active source is sent as code 3'b111 (parameter L1A_CODE).
- R7: A level-1 accept is sent before any broadcast command. A broadcast command that cannot go out in its own cycle is held and sent next. A held command goes out before a newer one, and the newer one is then held. If a level-1 accept, a held command and a new command all meet in one cycle, the held command is replaced by the new one.
- R8: The mode in effect takes the requested value only at an edge where both the command register and the held command are 3'b000. Otherwise the mode stays unchanged.
- R9: Address 0x41 bit 0 reads 1 while local mode is in effect and 0 while remote mode is in effect. Writes to this address have no effect. Unmapped addresses read 0.
- R10: After a synchronous active-low reset, all outputs are idle, local mode is in effect, the force bit is 0 and every table entry is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ready | input | 1 | Timing receiver ready flag |
| rx_l1a | input | 1 | Remote level-1 accept strobe |
| rx_bcast_valid | input | 1 | Remote broadcast byte valid |
| rx_bcast_code | input | 8 | Remote broadcast byte |
| loc_l1a | input | 1 | Local level-1 accept strobe |
| loc_cmd_valid | input | 1 | Local ring command valid |
| loc_cmd | input | 3 | Local ring command |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 3 | Register write data |
| cfg_rdata | output | 3 | Register read data (combinational) |
| ring_cmd | output | 24 | Ring commands, 3 bits per ring, 8 rings |
| bp_cmd | output | 3 | Backplane command |

## Verification
The hardest case to reach from the ports is a mode change that has been requested but must wait because a command is in flight. It only arises when rx_ready drops, or the force bit changes, while commands arrive back to back. A directed sequence first starts a remote broadcast, then drops rx_ready while broadcasts keep arriving, and checks that the status bit stays remote until the first edge with an empty pipeline. Long random runs also flip rx_ready and the force bit during dense traffic that mixes simultaneous accept and broadcast events, and compare every cycle against a bench model.

// File: rtl/tcr_pkg.sv
// Package: shared command type and widths for the trigger command router.
// Assumes 3-bit ring commands in which all-zero means idle.
package tcr_pkg;
    localparam int CMD_W = 3;
    typedef logic [CMD_W-1:0] rcmd_t;
    localparam rcmd_t CMD_IDLE = '0;
endpackage

// File: rtl/tcr_lut.sv
// Module: broadcast-to-ring translation table.
// A register array indexed by the upper broadcast bits. It has one write port
// and two combinational read ports: one for the mapping path, one for software.
// Assumes the write and the lookup of the same entry in one cycle see the old value.
module tcr_lut
    import tcr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rcmd_t            wr_val,
    input  logic [IDX_W-1:0] map_idx,
    output rcmd_t            map_val,
    input  logic [IDX_W-1:0] sw_idx,
    output rcmd_t            sw_val
);
    localparam int DEPTH = 1 << IDX_W;

    rcmd_t tbl_q [DEPTH];

    // Clear all entries on reset, otherwise store one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= CMD_IDLE;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_val;
        end
    end

    // Read ports.
    assign map_val = tbl_q[map_idx];
    assign sw_val  = tbl_q[sw_idx];
endmodule

// File: rtl/tcr_cfg.sv
// Module: register port decoder.
// Table entries sit at 0..DEPTH-1, the control register at DEPTH and status at DEPTH+1.
// Assumes single-cycle writes and a combinational read.
module tcr_cfg
    import tcr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W:0]   cfg_addr,
    input  rcmd_t            cfg_wdata,
    output rcmd_t            cfg_rdata,
    input  logic             active_local,
    input  rcmd_t            lut_rd,
    output logic             lut_we,
    output logic [IDX_W-1:0] lut_idx,
    output logic             force_local
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W:0] CTRL_ADDR = (IDX_W+1)'(DEPTH);
    localparam logic [IDX_W:0] STAT_ADDR = (IDX_W+1)'(DEPTH + 1);

    logic is_tbl;
    logic force_q;

    // Decode the table window from the top address bit.
    assign is_tbl  = ~cfg_addr[IDX_W];
    assign lut_idx = cfg_addr[IDX_W-1:0];
    assign lut_we  = cfg_we & is_tbl;

    // Control register: holds the force-local bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= 1'b0;
        end else if (cfg_we && cfg_addr == CTRL_ADDR) begin
            force_q <= cfg_wdata[0];
        end
    end
    assign force_local = force_q;

    // Read mux: table entry, control, status, or zero.
    always_comb begin
        cfg_rdata = CMD_IDLE;
        if (is_tbl) begin
            cfg_rdata = lut_rd;
        end else if (cfg_addr == CTRL_ADDR) begin
            cfg_rdata = {{(CMD_W-1){1'b0}}, force_q};
        end else if (cfg_addr == STAT_ADDR) begin
            cfg_rdata = {{(CMD_W-1){1'b0}}, active_local};
        end
    end
endmodule

// File: rtl/tcr_mode_ctrl.sv
// Module: mode-in-effect register.
// The requested mode is local when forced or when the receiver is not ready.
// It is taken over only when the output pipeline is idle. Reset state is local.
module tcr_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic force_local,
    input  logic rx_ready,
    input  logic pipe_idle,
    output logic active_local
);
    logic want_local;
    logic local_q;

    // Requested mode from the force bit and the receiver-ready flag.
    assign want_local = force_local | ~rx_ready;

    // Update the mode in effect only at edges with nothing in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_q <= 1'b1;
        end else if (pipe_idle) begin
            local_q <= want_local;
        end
    end
    assign active_local = local_q;
endmodule

// File: rtl/tcr_arbiter.sv
// Module: output command register with a one-deep hold slot.
// Order is level-1 accept, then the held command, then the new command.
// Assumes commands last a single cycle. A new command that cannot go out is held.
module tcr_arbiter
    import tcr_pkg::*;
#(
    parameter rcmd_t L1A_CODE = 3'b111
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  l1a,
    input  rcmd_t new_cmd,
    output rcmd_t out_q,
    output rcmd_t hold_q,
    output logic  pipe_idle
);
    rcmd_t out_d, hold_d;
    logic  have_hold, have_new;

    assign have_hold = (hold_q != CMD_IDLE);
    assign have_new  = (new_cmd != CMD_IDLE);

    // Choose the next output and the next held command.
    always_comb begin
        if (l1a) begin
            out_d  = L1A_CODE;
            hold_d = have_new ? new_cmd : hold_q;
        end else if (have_hold) begin
            out_d  = hold_q;
            hold_d = new_cmd;
        end else begin
            out_d  = new_cmd;
            hold_d = CMD_IDLE;
        end
    end

    // Output and hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= CMD_IDLE;
            hold_q <= CMD_IDLE;
        end else begin
            out_q  <= out_d;
            hold_q <= hold_d;
        end
    end

    // Pipeline is idle when nothing is on the output and nothing is held.
    assign pipe_idle = (out_q == CMD_IDLE) && !have_hold;
endmodule

// File: rtl/trig_cmd_router.sv
// Module: trigger command source selector and mapper (top).
// Picks the remote or local trigger source, maps remote broadcast bytes through
// a writable table, orders level-1 accepts ahead of broadcasts, and fans the
// result out to every ring slot and to the backplane.
// Assumes all inputs are synchronous to clk.
module trig_cmd_router
    import tcr_pkg::*;
#(
    parameter int    NUM_RINGS = 8,
    parameter int    BC_W      = 8,
    parameter int    IDX_W     = 6,
    parameter rcmd_t L1A_CODE  = 3'b111
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_ready,
    input  logic                       rx_l1a,
    input  logic                       rx_bcast_valid,
    input  logic [BC_W-1:0]            rx_bcast_code,
    input  logic                       loc_l1a,
    input  logic                       loc_cmd_valid,
    input  logic [CMD_W-1:0]           loc_cmd,
    input  logic                       cfg_we,
    input  logic [IDX_W:0]             cfg_addr,
    input  logic [CMD_W-1:0]           cfg_wdata,
    output logic [CMD_W-1:0]           cfg_rdata,
    output logic [NUM_RINGS*CMD_W-1:0] ring_cmd,
    output logic [CMD_W-1:0]           bp_cmd
);
    localparam int DROP_W = BC_W - IDX_W;

    logic             active_local, force_local, pipe_idle;
    logic             lut_we;
    logic [IDX_W-1:0] lut_idx;
    rcmd_t            lut_rd, map_val, out_q, hold_q, sel_cmd;
    logic             sel_l1a;
    logic [DROP_W-1:0] unused_low;

    // The low broadcast bits do not take part in the mapping.
    assign unused_low = rx_bcast_code[DROP_W-1:0];

    tcr_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .active_local(active_local), .lut_rd(lut_rd),
        .lut_we(lut_we), .lut_idx(lut_idx), .force_local(force_local)
    );

    tcr_lut #(.IDX_W(IDX_W)) u_lut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lut_we), .wr_idx(lut_idx), .wr_val(cfg_wdata),
        .map_idx(rx_bcast_code[BC_W-1 -: IDX_W]), .map_val(map_val),
        .sw_idx(lut_idx), .sw_val(lut_rd)
    );

    tcr_mode_ctrl u_mode (
        .clk(clk), .rst_n(rst_n),
        .force_local(force_local), .rx_ready(rx_ready),
        .pipe_idle(pipe_idle), .active_local(active_local)
    );

    // Source select: the mode in effect picks the strobe and the command.
    always_comb begin
        if (active_local) begin
            sel_l1a = loc_l1a;
            sel_cmd = loc_cmd_valid ? loc_cmd : CMD_IDLE;
        end else begin
            sel_l1a = rx_l1a;
            sel_cmd = rx_bcast_valid ? map_val : CMD_IDLE;
        end
    end

    tcr_arbiter #(.L1A_CODE(L1A_CODE)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .l1a(sel_l1a), .new_cmd(sel_cmd),
        .out_q(out_q), .hold_q(hold_q), .pipe_idle(pipe_idle)
    );

    // Fan the command register out to every ring slot.
    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        assign ring_cmd[g*CMD_W +: CMD_W] = out_q;
    end
    assign bp_cmd = out_q;
endmodule

// File: rtl/tcr_checker.sv
// Module: property checker for the trigger command router, bound to the top.
// Observes the ports and the mode and hold state. It drives nothing.
module tcr_checker
    import tcr_pkg::*;
#(
    parameter rcmd_t L1A_CODE = 3'b111
) (
    input logic  clk,
    input logic  rst_n,
    input logic  rx_ready,
    input logic  rx_l1a,
    input logic  loc_l1a,
    input logic  loc_cmd_valid,
    input logic  force_local,
    input logic  active_local,
    input rcmd_t hold_q,
    input rcmd_t bp_cmd
);
    AST_REMOTE_L1A_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_local && rx_l1a) |=> (bp_cmd == L1A_CODE)); // R6

    AST_LOCAL_IGNORES_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_local && !loc_l1a && !loc_cmd_valid && hold_q == CMD_IDLE) |=> (bp_cmd == CMD_IDLE)); // R1

    AST_MODE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_cmd != CMD_IDLE || hold_q != CMD_IDLE) |=> $stable(active_local)); // R8

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_local && bp_cmd == CMD_IDLE && hold_q == CMD_IDLE) |=> active_local); // R3

    AST_AUTO_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_local && rx_ready && bp_cmd == CMD_IDLE && hold_q == CMD_IDLE) |=> !active_local); // R2
endmodule

bind trig_cmd_router tcr_checker #(.L1A_CODE(L1A_CODE)) u_tcr_chk (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_l1a(rx_l1a),
    .loc_l1a(loc_l1a), .loc_cmd_valid(loc_cmd_valid),
    .force_local(force_local), .active_local(active_local),
    .hold_q(hold_q), .bp_cmd(bp_cmd)
);

// File: tb/tb_trig_cmd_router.sv
module tb_trig_cmd_router;
    localparam int NR = 8;
    localparam logic [6:0] A_CTRL = 7'h40;
    localparam logic [6:0] A_STAT = 7'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_ready = 1'b0, rx_l1a = 1'b0, rx_bcast_valid = 1'b0;
    logic [7:0]  rx_bcast_code = '0;
    logic        loc_l1a = 1'b0, loc_cmd_valid = 1'b0;
    logic [2:0]  loc_cmd = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = A_STAT;
    logic [2:0]  cfg_wdata = '0;
    logic [2:0]  cfg_rdata;
    logic [NR*3-1:0] ring_cmd;
    logic [2:0]  bp_cmd;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic       m_local, m_force;
    logic [2:0] m_out, m_hold;
    logic [2:0] m_lut [64];

    trig_cmd_router dut (
        .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_l1a(rx_l1a),
        .rx_bcast_valid(rx_bcast_valid), .rx_bcast_code(rx_bcast_code),
        .loc_l1a(loc_l1a), .loc_cmd_valid(loc_cmd_valid), .loc_cmd(loc_cmd),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ring_cmd(ring_cmd), .bp_cmd(bp_cmd)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_rdata(input logic [6:0] a);
        if (a < 7'd64) return m_lut[a[5:0]];
        if (a == A_CTRL) return {2'b0, m_force};
        if (a == A_STAT) return {2'b0, m_local};
        return 3'b000;
    endfunction

    task automatic model_reset();
        m_local = 1'b1; m_force = 1'b0; m_out = '0; m_hold = '0;
        for (int i = 0; i < 64; i++) m_lut[i] = '0;
    endtask

    // One clock: compute the model's next state, take the edge, compare all outputs.
    task automatic step();
        logic       l1a, nloc;
        logic [2:0] nc, no, nh;
        l1a = m_local ? loc_l1a : rx_l1a;
        nc  = m_local ? (loc_cmd_valid ? loc_cmd : 3'b000)
                      : (rx_bcast_valid ? m_lut[rx_bcast_code[7:2]] : 3'b000);
        if (l1a) begin
            no = 3'b111; nh = (nc != 0) ? nc : m_hold;
        end else if (m_hold != 0) begin
            no = m_hold; nh = nc;
        end else begin
            no = nc; nh = 3'b000;
        end
        nloc = (m_out == 0 && m_hold == 0) ? (m_force | ~rx_ready) : m_local;
        @(posedge clk);
        if (cfg_we) begin
            if (cfg_addr < 7'd64) m_lut[cfg_addr[5:0]] = cfg_wdata;
            else if (cfg_addr == A_CTRL) m_force = cfg_wdata[0];
        end
        m_out = no; m_hold = nh; m_local = nloc;
        #2;
        check("R5 backplane", bp_cmd, m_out);
        for (int r = 0; r < NR; r++) check("R5 ring", ring_cmd[r*3 +: 3], m_out);
        check("R9 readback", cfg_rdata, exp_rdata(cfg_addr));
    endtask

    task automatic idle_in();
        rx_l1a = 0; rx_bcast_valid = 0; loc_l1a = 0; loc_cmd_valid = 0; cfg_we = 0;
        cfg_addr = A_STAT;
    endtask

    task automatic wr(input logic [6:0] a, input logic [2:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 0; cfg_addr = A_STAT;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R10: reset state
        check("R10 bp idle", bp_cmd, 0);
        check("R10 ring idle", ring_cmd, 0);
        check("R10 status local", cfg_rdata, 1);
        cfg_addr = A_CTRL; #1;
        check("R10 force clear", cfg_rdata, 0);
        cfg_addr = 7'd9; #1;
        check("R10 table clear", cfg_rdata, 0);
        cfg_addr = A_STAT;

        // Load the table with random values, entry 0 idle, entry 5 = 2.
        for (int i = 0; i < 64; i++) wr(7'(i), (i == 0) ? 3'd0 : (i == 5) ? 3'd2 : 3'($urandom));
        cfg_addr = 7'd5; #1;
        check("R4 table readback", cfg_rdata, 2);
        cfg_addr = A_STAT;

        // R2: ready high -> remote
        rx_ready = 1; step(); step();
        check("R2 remote when ready", cfg_rdata, 0);

        // R6/R7: accept and broadcast in one cycle
        rx_l1a = 1; rx_bcast_valid = 1; rx_bcast_code = {6'd5, 2'b11};
        step();
        check("R6 accept code", bp_cmd, 7);
        idle_in(); step();
        check("R7 held broadcast next", bp_cmd, 2);
        step();
        check("R7 drained", bp_cmd, 0);

        // R4: entry 0 produces no command
        rx_bcast_valid = 1; rx_bcast_code = 8'h03; step(); idle_in();
        check("R4 zero entry idle", bp_cmd, 0);

        // R8: deferred mode change while busy
        rx_bcast_valid = 1; rx_bcast_code = {6'd5, 2'b00}; step();
        rx_ready = 0; step();
        check("R8 stays remote busy", cfg_rdata, 0);
        idle_in(); step();
        check("R8 stays remote draining", cfg_rdata, 0);
        step();
        check("R8 local after idle", cfg_rdata, 1);

        // R3: force local with ready high
        rx_ready = 1; step(); step();
        check("R2 back to remote", cfg_rdata, 0);
        wr(A_CTRL, 3'd1); step(); step();
        check("R3 forced local", cfg_rdata, 1);
        // R1: remote ignored in local mode, local forwarded
        rx_l1a = 1; rx_bcast_valid = 1; rx_bcast_code = {6'd5, 2'b00}; step(); idle_in();
        check("R1 remote ignored", bp_cmd, 0);
        loc_cmd_valid = 1; loc_cmd = 3'd3; step(); idle_in();
        check("R1 local forwarded", bp_cmd, 3);
        // R9: status write ignored
        wr(A_STAT, 3'd0);
        check("R9 status read-only", cfg_rdata, 1);
        cfg_addr = 7'h50; #1;
        check("R9 unmapped zero", cfg_rdata, 0);
        cfg_addr = A_STAT;
        wr(A_CTRL, 3'd0);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            rx_l1a         = ($urandom % 5) == 0;
            rx_bcast_valid = ($urandom % 3) == 0;
            rx_bcast_code  = 8'($urandom);
            loc_l1a        = ($urandom % 5) == 0;
            loc_cmd_valid  = ($urandom % 3) == 0;
            loc_cmd        = 3'($urandom);
            if (($urandom % 25) == 0) rx_ready = ~rx_ready;
            cfg_we = 0;
            cfg_addr = 7'($urandom % 68);
            if (($urandom % 40) == 0) begin
                cfg_we = 1;
                cfg_wdata = 3'($urandom);
                if (($urandom % 2) == 0) cfg_addr = A_CTRL;
            end
            step();
        end
        idle_in(); step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule